// File: doc/BRIEF.md
# Timer Channel Status Flags

This block holds the three sticky status flags of one 16-bit timer channel and turns them into interrupt requests. The counter logic reports events as one-cycle strobes. An upward wrap of the counter (0xFFFF to 0x0000) or a downward wrap (0x0000 to 0xFFFF) sets the wrap flag. A compare match or input capture on general register A or general register B sets that register's own flag. Each flag is ANDed with an enable bit supplied from outside to form its interrupt request.

Software sees the flags through an 8-bit register port. The read data is combinational and always valid. A read strobe marks the cycle in which software samples the register. Clearing takes two steps, and the steps must come in order:

1. Software reads the flag as 1.
2. Software then writes 0 to that bit.

A write of 0 without the earlier read leaves the flag set. Any new event on a flag cancels an earlier read of that flag.

The access pins are plain strobes with no handshake. The register takes a write in the cycle `wr_en` is high, and it never stalls.

Top module: `tsf_status_reg`

## Requirements
- R1: After reset, and in the cycle after `standby` is high, the register reads 0xF8 (all flags 0, all read-arms cleared). `standby` overrides any event or write in the same cycle.
- R2: Bits 7..3 always read 1, and writes to them have no effect.
- R3: A `cnt_wrap_up` strobe sets bit 2 (the wrap flag) in the next cycle.
- R4: A `cnt_wrap_down` strobe sets bit 2 only while `updown_mode` is 1. When `updown_mode` is 0, that strobe leaves bit 2 unchanged.
- R5: A `match_b` strobe sets bit 1, and a `match_a` strobe sets bit 0, in the next cycle. Each strobe affects no other bit.
- R6: A write of 0 to a flag that has not been read as 1 since it last set leaves the flag at 1.
- R7: A read (`rd_en`=1) while a flag is 1 arms that flag. A later write with that bit 0 clears it in the next cycle and disarms it. A write with that bit 1 leaves both the flag and its arm unchanged.
- R8: If a set event and a valid clear reach the same flag in the same cycle, the flag stays 1.
- R9: A set event disarms its flag. After the event, a write of 0 does not clear the flag until the flag has been read as 1 again.
- R10: `irq[i]` equals flag bit i ANDed with `irq_en[i]`, in the same cycle as the registered flag.
- R11: A read arms only the flags that read 1. If a flag reads 0 at the read and sets later, a write of 0 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous return to the reset state |
| cnt_wrap_up | input | 1 | Counter wrapped from 0xFFFF to 0x0000 |
| cnt_wrap_down | input | 1 | Counter wrapped from 0x0000 to 0xFFFF |
| updown_mode | input | 1 | Channel counts in both directions |
| match_a | input | 1 | Compare match or capture on register A |
| match_b | input | 1 | Compare match or capture on register B |
| rd_en | input | 1 | Software read strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register contents |
| irq_en | input | 3 | Interrupt enables, bit order as the flags |
| irq | output | 3 | Interrupt requests, bit order as the flags |

## Verification
The bench builds the block with its default parameters: an 8-bit register with three flags. At these values every flag position and every reserved bit is reachable. A random run drives event strobes, reads, writes and standby with uneven probabilities. Under this stimulus, reads, clears and set events land on the same flag in the same or adjacent cycles, which exercises the arm-then-clear ordering and set-over-clear priority far more often than a plain driver would.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int TSF_FLAGS = 3;
  localparam int FLG_A     = 0;
  localparam int FLG_B     = 1;
  localparam int FLG_WRAP  = 2;
endpackage

// File: rtl/tsf_event_map.sv
module tsf_event_map #(
  parameter int NUM_FLAGS = tsf_pkg::TSF_FLAGS
) (
  input  logic                 cnt_wrap_up,
  input  logic                 cnt_wrap_down,
  input  logic                 updown_mode,
  input  logic                 match_a,
  input  logic                 match_b,
  output logic [NUM_FLAGS-1:0] set_vec
);
  always_comb begin
    set_vec = '0;
    set_vec[tsf_pkg::FLG_A]    = match_a;
    set_vec[tsf_pkg::FLG_B]    = match_b;
    // a downward wrap only counts in bidirectional operation
    set_vec[tsf_pkg::FLG_WRAP] = cnt_wrap_up | (cnt_wrap_down & updown_mode);
  end
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic set_evt,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag
);
  logic armed;
  logic clr;
  logic flag_nxt;
  logic armed_nxt;

  assign clr = wr_en & ~wr_bit & armed;

  always_comb begin
    flag_nxt  = flag;
    armed_nxt = armed;
    if (set_evt) begin
      flag_nxt  = 1'b1;
      armed_nxt = 1'b0;
    end else if (clr) begin
      flag_nxt  = 1'b0;
      armed_nxt = 1'b0;
    end else if (rd_en && flag) begin
      armed_nxt = 1'b1;
    end
    if (standby) begin
      flag_nxt  = 1'b0;
      armed_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flag_nxt;
      armed <= armed_nxt;
    end
  end
endmodule

// File: rtl/tsf_status_reg.sv
module tsf_status_reg #(
  parameter int REG_W     = 8,
  parameter int NUM_FLAGS = tsf_pkg::TSF_FLAGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 cnt_wrap_up,
  input  logic                 cnt_wrap_down,
  input  logic                 updown_mode,
  input  logic                 match_a,
  input  logic                 match_b,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [NUM_FLAGS-1:0] irq
);
  localparam int RSV_W = REG_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flags;
  logic [RSV_W-1:0]     wr_unused;

  assign wr_unused = wr_data[REG_W-1:NUM_FLAGS];

  tsf_event_map #(.NUM_FLAGS(NUM_FLAGS)) u_map (
    .cnt_wrap_up  (cnt_wrap_up),
    .cnt_wrap_down(cnt_wrap_down),
    .updown_mode  (updown_mode),
    .match_a      (match_a),
    .match_b      (match_b),
    .set_vec      (set_vec)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tsf_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .standby(standby),
      .set_evt(set_vec[g]),
      .rd_en  (rd_en),
      .wr_en  (wr_en),
      .wr_bit (wr_data[g]),
      .flag   (flags[g])
    );
  end

  assign rd_data = {{RSV_W{1'b1}} | wr_unused | ~wr_unused, flags};
  assign irq     = flags & irq_en;
endmodule

// File: rtl/tsf_status_chk.sv
module tsf_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       standby,
  input logic       cnt_wrap_up,
  input logic       cnt_wrap_down,
  input logic       updown_mode,
  input logic       match_a,
  input logic       match_b,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [2:0] irq_en,
  input logic [2:0] irq
);
  // R1
  standby_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> rd_data == 8'hF8);
  // R2
  reserved_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:3] == 5'h1F);
  // R3
  wrap_up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap_up && !standby |=> rd_data[2]);
  // R4
  down_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap_down && !updown_mode && !cnt_wrap_up && !rd_data[2] && !standby |=> !rd_data[2]);
  // R5
  match_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_b && !standby |=> rd_data[1]);
  // R5
  match_a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_a && !standby |=> rd_data[0]);
  // R7
  write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[0] && rd_data[0] && !standby |=> rd_data[0]);
  // R7
  read_then_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) && $past(rd_data[0]) && !$past(match_a) && !$past(standby) && !$past(wr_en)
    && wr_en && !wr_data[0] && !match_a && !standby |=> !rd_data[0]);
  // R9
  set_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(match_a) && !$past(standby) && wr_en && !wr_data[0] && !standby |=> rd_data[0]);
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[2:0] & irq_en));
  // R4
  down_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap_down && updown_mode && !standby |=> rd_data[2]);
endmodule

bind tsf_status_reg tsf_status_chk u_tsf_chk (.*);

// File: tb/test_tsf_status_reg.sv
`timescale 1ns/1ps
module test_tsf_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       cnt_wrap_up = 1'b0, cnt_wrap_down = 1'b0, updown_mode = 1'b0;
  logic       match_a = 1'b0, match_b = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] irq_en = 3'b000;
  logic [2:0] irq;

  int checks = 0;
  int failures = 0;
  logic [2:0] mf = 3'b000;
  logic [2:0] ma = 3'b000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tsf_status_reg i_tsf_status_reg (.*);

  function automatic logic [2:0] set_of(logic up, logic dn, logic ud, logic b, logic a);
    return {up | (dn & ud), b, a};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_tick();
    logic [2:0] s;
    logic clr;
    s = set_of(cnt_wrap_up, cnt_wrap_down, updown_mode, match_b, match_a);
    for (int i = 0; i < 3; i++) begin
      clr = wr_en & ~wr_data[i] & ma[i];
      if (s[i]) begin mf[i] = 1'b1; ma[i] = 1'b0; end
      else if (clr) begin mf[i] = 1'b0; ma[i] = 1'b0; end
      else if (rd_en && mf[i]) ma[i] = 1'b1;
    end
    if (standby) begin mf = 3'b000; ma = 3'b000; end
  endtask

  // one cycle: drive at negedge, check outputs mid-cycle, advance model at posedge
  task automatic cyc(string tag, logic up, logic dn, logic ud, logic b, logic a,
                     logic rd, logic wr, logic [7:0] wd, logic sb);
    @(negedge clk);
    cnt_wrap_up = up; cnt_wrap_down = dn; updown_mode = ud;
    match_b = b; match_a = a; rd_en = rd; wr_en = wr; wr_data = wd; standby = sb;
    #1;
    chk(tag, rd_data, {5'h1F, mf});
    chk({tag, " R10"}, {5'h0, irq}, {5'h0, mf & irq_en});
    @(posedge clk);
    model_tick();
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    irq_en = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle("R1 reset");
    @(negedge clk); #1 chk("R1 reset value", rd_data, 8'hF8);

    // R2: writing ones to reserved bits, zeros too
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 8'hF8, 0);
    cyc("R2", 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    // R3 upward wrap
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    @(negedge clk); #1 chk("R3 wrap up", rd_data, 8'hFC);
    // R6 write 0 without read
    cyc("R6", 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    @(negedge clk); #1 chk("R6 no read no clear", rd_data, 8'hFC);
    // R7 read then write 1 keeps, then write 0 clears
    cyc("R7", 0, 0, 0, 0, 0, 1, 0, 8'h00, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0);
    @(negedge clk); #1 chk("R7 write one keeps", rd_data, 8'hFC);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    @(negedge clk); #1 chk("R7 clear after read", rd_data, 8'hF8);
    // R4 downward wrap gated by mode
    cyc("R4", 0, 1, 0, 0, 0, 0, 0, 8'h00, 0);
    @(negedge clk); #1 chk("R4 down ignored", rd_data, 8'hF8);
    cyc("R4", 0, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    @(negedge clk); #1 chk("R4 down counts", rd_data, 8'hFC);
    // R5 per-register flags
    cyc("R5", 0, 0, 0, 1, 0, 0, 0, 8'h00, 0);
    @(negedge clk); #1 chk("R5 match B", rd_data, 8'hFE);
    cyc("R5", 0, 0, 0, 0, 1, 0, 0, 8'h00, 0);
    @(negedge clk); #1 chk("R5 match A", rd_data, 8'hFF);
    // R8 set and clear collide on bit 0
    cyc("R8", 0, 0, 0, 0, 0, 1, 0, 8'h00, 0);
    cyc("R8", 0, 0, 0, 0, 1, 0, 1, 8'hFE, 0);
    @(negedge clk); #1 chk("R8 set wins", rd_data, 8'hFF);
    // R9 arm lost after the set above: write 0 must not clear bit 0
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 8'hFE, 0);
    @(negedge clk); #1 chk("R9 reread needed", rd_data, 8'hFF);
    // R1 standby wins over events
    cyc("R1", 1, 0, 0, 1, 1, 0, 0, 8'h00, 1);
    @(negedge clk); #1 chk("R1 standby", rd_data, 8'hF8);
    // R11 read while 0 does not arm
    cyc("R11", 0, 0, 0, 0, 0, 1, 0, 8'h00, 0);
    cyc("R11", 0, 0, 0, 1, 0, 0, 0, 8'h00, 0);
    cyc("R11", 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    @(negedge clk); #1 chk("R11 unarmed", rd_data, 8'hFA);
    // R10 enable masking
    @(negedge clk); irq_en = 3'b001; #1 chk("R10 masked irq", {5'h0, irq}, 8'h00);
    irq_en = 3'b010; #1 chk("R10 enabled irq", {5'h0, irq}, 8'h02);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      irq_en = 3'($urandom);
      cyc("R3 R5 R7 R8 R9 random",
          ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 2) == 0,
          ($urandom % 6) == 0, ($urandom % 6) == 0,
          ($urandom % 3) == 0, ($urandom % 3) == 0, 8'($urandom),
          ($urandom % 200) == 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule